// File: doc/BRIEF.md
# Two-Phase Sampled Track Packet Receiver

This block listens to a single-wire track data line and turns the serial traffic into packets. It waits, idle, for a rising edge on the line. That edge starts reception. From then on, an internal divider produces a sample tick every `TICK_DIV` clock cycles. At the default setting one tick is 50 µs at 125 MHz.

Each data bit spans two ticks. The first tick only records the line level. The second tick either shifts a bit in or recognises the end of the packet. The start pulse is itself taken as the first bit: the first tick after the start edge is a second-phase sample.

When a packet closes, the block pulses a valid strobe and reports the bit count. A 10-bit packet is a controller packet. For such a packet the block decodes a car index, a 4-bit speed and a lane-change flag, and stores speed and flag in an eight-entry per-car table that can be read at any time. A pending reply armed for one car fires a one-cycle strobe when a controller packet for that car arrives.

Top module: `track_pkt_rx`

## Requirements
- R1: After reset the receiver is idle, all strobes are 0, the length and car outputs are 0, no reply is pending, and every table entry reads speed 0 and lane flag 0.
- R2: While idle, a 0-to-1 transition of `line_i` starts a packet. The first sample tick after it takes the start bit, which is shifted in as the line level (1) and counted as bit one.
- R3: Sample ticks fall every `TICK_DIV` clock cycles, counted from the start edge. Ticks alternate between a first phase, which only stores the level, and a second phase. A second phase that is not an end shifts the current line level into the word LSB-first-in (earlier bits move up) and adds one to a 6-bit count.
- R4: When the line is low in both the first and the second sample of a bit slot, the packet ends. `pkt_valid_o` pulses high for exactly one cycle, `pkt_len_o` shows the number of bits received including the start bit, and the receiver returns to waiting for an edge.
- R5: Rising edges on `line_i` while a packet is being received do not restart reception or disturb the word or the count.
- R6: On a packet of length 10, with word bit 0 the last bit received, the car index is bits [8:6], the speed is bits [4:1] and the lane flag is bit 5. `ctrl_pkt_o` is high with `pkt_valid_o`, `car_o` shows the index, and the table entry of that car takes the new speed and flag.
- R7: A packet of any length other than 10 leaves `ctrl_pkt_o` low and changes no table entry.
- R8: A reply armed with `reply_load_i` for car c fires `reply_fire_o` in the `pkt_valid_o` cycle of a controller packet whose index is c. `reply_pend_o` is 0 from that cycle on.
- R9: A controller packet for a different car, or a packet of another length, neither fires nor clears the armed reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Track data line, already synchronised |
| reply_load_i | input | 1 | Arms a reply for `reply_car_i` |
| reply_car_i | input | 3 | Car index of the reply to arm |
| rd_idx_i | input | 3 | Table read index |
| pkt_valid_o | output | 1 | One-cycle strobe at packet end |
| pkt_len_o | output | 6 | Bit count of the last packet |
| ctrl_pkt_o | output | 1 | Last packet was a controller packet (valid with strobe) |
| car_o | output | 3 | Car index of the last controller packet |
| reply_fire_o | output | 1 | One-cycle strobe: armed reply matched |
| reply_pend_o | output | 1 | A reply is armed |
| rd_speed_o | output | 4 | Speed stored for car `rd_idx_i` |
| rd_lane_o | output | 1 | Lane-change flag stored for car `rd_idx_i` |

## Verification
The hardest state to reach is a rising edge that arrives mid-packet, because it must be ignored. The block never sees one unless a zero bit is followed by the high first phase of the next slot. The stimulus therefore encodes every bit as a high first phase followed by the data level. Every zero in the walked vectors then produces such an edge while the receiver is busy, and the decoded fields show whether the word or count was disturbed. Reply matching is reached by arming a car, then sending a mismatching controller packet, a ten-bit-looking packet of the wrong length, and finally the matching one.

// File: rtl/track_rx_pkg.sv
package track_rx_pkg;
  localparam int unsigned CNT_W    = 6;
  localparam int unsigned CAR_W    = 3;
  localparam int unsigned SPEED_W  = 4;
  localparam int unsigned CTRL_LEN = 10;
  localparam int unsigned NUM_CARS = 1 << CAR_W;
  localparam int unsigned LANE_BIT = SPEED_W + 1;
  localparam int unsigned CAR_LSB  = SPEED_W + 2;
  localparam int unsigned FIELD_W  = CAR_LSB + CAR_W;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;

  typedef struct packed {
    logic               lane;
    logic [SPEED_W-1:0] speed;
  } car_ent_t;
endpackage

// File: rtl/track_rx_tick.sv
module track_rx_tick #(
  parameter int unsigned DIV = 6250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || !run_i || tick_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_chk
      // R3
      tick_after_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/track_rx_sampler.sv
module track_rx_sampler
  import track_rx_pkg::*;
#(
  parameter int unsigned SHIFT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               start_o,
  output logic               done_o,
  output logic [SHIFT_W-1:0] word_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic               line_q, busy_q, low_q;
  phase_e             phase_q;
  logic [SHIFT_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rise, end_evt;

  assign rise    = line_i && !line_q;
  assign start_o = !busy_q && rise;
  assign end_evt = busy_q && tick_i && (phase_q == PH_SECOND) && low_q && !line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= 1'b0;
      busy_q  <= 1'b0;
      low_q   <= 1'b0;
      phase_q <= PH_FIRST;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      line_q <= line_i;
      if (start_o) begin
        // start pulse stands in for the first phase of bit one
        busy_q  <= 1'b1;
        phase_q <= PH_SECOND;
        low_q   <= 1'b0;
        sh_q    <= '0;
        cnt_q   <= '0;
      end else if (busy_q && tick_i) begin
        if (phase_q == PH_FIRST) begin
          low_q   <= !line_i;
          phase_q <= PH_SECOND;
        end else if (end_evt) begin
          busy_q  <= 1'b0;
          phase_q <= PH_FIRST;
        end else begin
          sh_q    <= {sh_q[SHIFT_W-2:0], line_i};
          cnt_q   <= cnt_q + 1'b1;
          phase_q <= PH_FIRST;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = end_evt;
  assign word_o = sh_q;
  assign cnt_o  = cnt_q;

  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_q && (cnt_q == '0) && (phase_q == PH_SECOND));
  // R5
  busy_edge_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rise && !tick_i) |=> $stable(cnt_q) && $stable(sh_q) && busy_q);
  // R3
  first_phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && phase_q == PH_FIRST) |=> $stable(cnt_q) && $stable(sh_q));
endmodule

// File: rtl/track_rx_table.sv
module track_rx_table
  import track_rx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic [FIELD_W-1:1] field_i,
  input  logic               reply_load_i,
  input  logic [CAR_W-1:0]   reply_car_i,
  input  logic [CAR_W-1:0]   rd_idx_i,
  output logic               ctrl_o,
  output logic [CAR_W-1:0]   car_o,
  output logic               fire_o,
  output logic               pend_o,
  output logic [SPEED_W-1:0] rd_speed_o,
  output logic               rd_lane_o
);
  logic             is_ctrl, hit;
  logic [CAR_W-1:0] car;
  car_ent_t         new_ent;
  car_ent_t         tbl_q [NUM_CARS];
  logic             ctrl_q, fire_q, pend_q;
  logic [CAR_W-1:0] car_q, pend_car_q;

  assign is_ctrl       = done_i && (len_i == CNT_W'(CTRL_LEN));
  assign car           = field_i[FIELD_W-1:CAR_LSB];
  assign new_ent.lane  = field_i[LANE_BIT];
  assign new_ent.speed = field_i[SPEED_W:1];
  assign hit           = is_ctrl && pend_q && (pend_car_q == car);

  generate
    for (genvar i = 0; i < NUM_CARS; i++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  tbl_q[i] <= '0;
        else if (is_ctrl && car == CAR_W'(i))         tbl_q[i] <= new_ent;
      end
      // R7
      ent_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tbl_q[i]) |-> $past(is_ctrl && car == CAR_W'(i)));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= 1'b0;
      car_q      <= '0;
      fire_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_car_q <= '0;
    end else begin
      ctrl_q <= is_ctrl;
      fire_q <= hit;
      if (is_ctrl) car_q <= car;
      if (reply_load_i) begin
        pend_q     <= 1'b1;
        pend_car_q <= reply_car_i;
      end else if (hit) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign car_o      = car_q;
  assign fire_o     = fire_q;
  assign pend_o     = pend_q;
  assign rd_speed_o = tbl_q[rd_idx_i].speed;
  assign rd_lane_o  = tbl_q[rd_idx_i].lane;

  // R8
  fire_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_q && !$past(reply_load_i)) |-> (!pend_q && $past(pend_q)));
  // R9
  pend_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !hit) |=> pend_q);
endmodule

// File: rtl/track_pkt_rx.sv
module track_pkt_rx
  import track_rx_pkg::*;
#(
  parameter int unsigned TICK_DIV = 6250,
  parameter int unsigned SHIFT_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_i,
  input  logic               reply_load_i,
  input  logic [CAR_W-1:0]   reply_car_i,
  input  logic [CAR_W-1:0]   rd_idx_i,
  output logic               pkt_valid_o,
  output logic [CNT_W-1:0]   pkt_len_o,
  output logic               ctrl_pkt_o,
  output logic [CAR_W-1:0]   car_o,
  output logic               reply_fire_o,
  output logic               reply_pend_o,
  output logic [SPEED_W-1:0] rd_speed_o,
  output logic               rd_lane_o
);
  logic               tick, busy, start, done;
  logic [SHIFT_W-1:0] word;
  logic [CNT_W-1:0]   cnt;
  logic               valid_q;
  logic [CNT_W-1:0]   len_q;
  logic               unused_word;

  assign unused_word = ^{word[SHIFT_W-1:FIELD_W], word[0]};

  track_rx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .clr_i  (start),
    .tick_o (tick)
  );

  track_rx_sampler #(.SHIFT_W(SHIFT_W)) u_samp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .tick_i  (tick),
    .busy_o  (busy),
    .start_o (start),
    .done_o  (done),
    .word_o  (word),
    .cnt_o   (cnt)
  );

  track_rx_table u_tbl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .done_i       (done),
    .len_i        (cnt),
    .field_i      (word[FIELD_W-1:1]),
    .reply_load_i (reply_load_i),
    .reply_car_i  (reply_car_i),
    .rd_idx_i     (rd_idx_i),
    .ctrl_o       (ctrl_pkt_o),
    .car_o        (car_o),
    .fire_o       (reply_fire_o),
    .pend_o       (reply_pend_o),
    .rd_speed_o   (rd_speed_o),
    .rd_lane_o    (rd_lane_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      len_q   <= '0;
    end else begin
      valid_q <= done;
      if (done) len_q <= cnt;
    end
  end

  assign pkt_valid_o = valid_q;
  assign pkt_len_o   = len_q;

  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |=> !pkt_valid_o);
  // R8
  fire_with_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_fire_o |-> (pkt_valid_o && ctrl_pkt_o));
  // R6
  ctrl_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_pkt_o |-> (pkt_valid_o && pkt_len_o == CNT_W'(CTRL_LEN)));
endmodule

// File: tb/track_pkt_rx_tb.sv
module track_pkt_rx_tb;
  localparam int unsigned DIV = 8;
  localparam int NVEC = 7;

  typedef struct packed {
    logic [15:0] word;
    logic [5:0]  len;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'h02EA, 6'd10},  // car3 lane1 speed5
    '{16'h021F, 6'd10},  // car0 lane0 speed15
    '{16'h03E1, 6'd10},  // car7 lane1 speed0
    '{16'h0016, 6'd5},
    '{16'h0ABC, 6'd12},
    '{16'h0001, 6'd1},
    '{16'h02C5, 6'd10}   // car3 lane0 speed2
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       rload = 1'b0;
  logic [2:0] rcar = '0;
  logic [2:0] ridx = '0;
  logic       pkt_valid, ctrl_pkt, rfire, rpend, rlane;
  logic [5:0] plen;
  logic [2:0] car;
  logic [3:0] rspeed;

  int checks = 0;
  int errors = 0;
  int m_speed [8];
  int m_lane  [8];

  always #4 clk = ~clk;

  track_pkt_rx #(.TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .reply_load_i(rload), .reply_car_i(rcar), .rd_idx_i(ridx),
    .pkt_valid_o(pkt_valid), .pkt_len_o(plen), .ctrl_pkt_o(ctrl_pkt),
    .car_o(car), .reply_fire_o(rfire), .reply_pend_o(rpend),
    .rd_speed_o(rspeed), .rd_lane_o(rlane)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl);
    line = lvl;
    repeat (DIV) @(negedge clk);
  endtask

  // bit slot: high first phase, then data level; end: two low samples
  task automatic send(input logic [15:0] w, input int n, input bit exp_fire);
    int car_i;
    @(negedge clk);
    line = 1'b1;
    repeat (DIV + 1) @(negedge clk);
    for (int j = n - 2; j >= 0; j--) begin
      hold(1'b1);
      hold(w[j]);
    end
    hold(1'b0);
    line = 1'b0;
    repeat (DIV - 1) @(negedge clk);
    chk(pkt_valid == 1'b0, "R4 no early valid", pkt_valid, 0);
    @(negedge clk);
    chk(pkt_valid == 1'b1, "R4 valid at end", pkt_valid, 1);
    chk(plen == n[5:0], "R4 length", plen, n);
    chk(ctrl_pkt == (n == 10), "R6/R7 ctrl flag", ctrl_pkt, n == 10);
    chk(rfire == exp_fire, "R8/R9 reply fire", rfire, exp_fire);
    if (n == 10) begin
      car_i = int'(w[8:6]);
      chk(car == w[8:6], "R6 car index", car, car_i);
      m_speed[car_i] = int'(w[4:1]);
      m_lane[car_i]  = int'(w[5]);
    end
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R4 single pulse", pkt_valid, 0);
    chk(rfire == 1'b0, "R8 fire single pulse", rfire, 0);
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < 8; i++) begin
      ridx = 3'(i);
      #1;
      chk(rspeed == 4'(m_speed[i]), req, rspeed, m_speed[i]);
      chk(rlane == 1'(m_lane[i]), req, rlane, m_lane[i]);
    end
  endtask

  task automatic arm(input logic [2:0] c);
    @(negedge clk);
    rload = 1'b1;
    rcar  = c;
    @(negedge clk);
    rload = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_speed[i] = 0;
      m_lane[i]  = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pkt_valid == 1'b0, "R1 valid", pkt_valid, 0);
    chk(plen == '0, "R1 length", plen, 0);
    chk(ctrl_pkt == 1'b0, "R1 ctrl", ctrl_pkt, 0);
    chk(car == '0, "R1 car", car, 0);
    chk(rfire == 1'b0, "R1 fire", rfire, 0);
    chk(rpend == 1'b0, "R1 pending", rpend, 0);
    check_table("R1 table empty");

    // R2 R3 R5 R6 R7: vector walk; every zero bit causes a mid-packet rise
    for (int v = 0; v < NVEC; v++) begin
      send(VECS[v].word, int'(VECS[v].len), 1'b0);
      check_table("R6/R7 table contents");
    end

    // R9 mismatch keeps the reply armed
    arm(3'd2);
    chk(rpend == 1'b1, "R8 armed", rpend, 1);
    send(16'h0303, 10, 1'b0);              // car4
    chk(rpend == 1'b1, "R9 kept after other car", rpend, 1);
    send(16'h0083, 9, 1'b0);               // wrong length, bits[8:6]=2
    chk(rpend == 1'b1, "R9 kept after short packet", rpend, 1);
    check_table("R7 short packet ignored");
    // R8 match fires and clears
    send(16'h02A7, 10, 1'b1);              // car2 lane1 speed3
    chk(rpend == 1'b0, "R8 cleared", rpend, 0);
    arm(3'd5);
    send(16'h0361, 10, 1'b1);              // car5 lane1 speed0
    chk(rpend == 1'b0, "R8 cleared again", rpend, 0);
    send(16'h0361, 10, 1'b0);
    check_table("R6 final table");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule